// File: doc/BRIEF.md
# Flash Completion Polling Engine

A host-side sequencer that runs after a program or erase command has been sent to a parallel NOR flash. It decides when the embedded operation is over and whether it succeeded. On a start pulse it latches a target address and an expected status byte. It then repeatedly reads the status at that address through a request/grant/read-valid interface toward a bus master. It uses one of two detection methods, chosen at start. With data-complement polling it compares bit 7 of each read with bit 7 of the expected byte. With toggle detection it compares bit 6 across two back-to-back reads.

Bit 5 of a status read is the device's time-limit flag. When the flag is seen, the engine does not fail at once, because the operation may have completed in the same moment the flag rose. It makes one more check first and fails only if that check still shows the operation unfinished. A parameterised bound on the number of unfinished rounds turns a device that never answers into a fail. Every fail ends with a write of the return-to-read code 0xF0 so that the flash leaves its status-output state. For erase, the caller passes 0xFF as the expected byte and an address inside the sector being erased.

Top module: `cpe_engine`

## Requirements
- R1: After reset the engine is idle: bus_req, busy, done, pass and fail are all 0.
- R2: In polling mode (use_toggle=0) every read goes to the latched address. A read whose bit 7 equals bit 7 of expect_stat ends the run with pass, even when bit 5 is also set.
- R3: In polling mode, a read with bit 7 unequal and bit 5 = 0 leads to another read. A read with bit 7 unequal and bit 5 = 1 leads to exactly one more read, which gives pass if its bit 7 matches and fail otherwise.
- R4: In toggle mode (use_toggle=1) status reads are taken in pairs. A pair whose two bit 6 values are equal ends the run with pass.
- R5: In toggle mode, a pair with unequal bit 6 values and bit 5 = 0 in its second read leads to another pair. If that bit 5 is 1, exactly one more pair is read, and a difference in bit 6 there gives fail.
- R6: Every fail is preceded by exactly one write (bus_we=1) of data 0x00F0 to the latched address. A pass run performs no write.
- R7: Once raised, bus_req holds with stable bus_addr and bus_we until bus_gnt. It is low in the cycle after each grant, so every access is a separate bus cycle.
- R8: A read result is taken only in a cycle with bus_rvalid=1; bus_rdata in other cycles has no effect.
- R9: After MAX_POLLS unfinished rounds with bit 5 = 0 (single reads in polling mode, pairs in toggle mode), the run ends with fail.
- R10: done is a one-cycle pulse during which exactly one of pass and fail is 1. busy is 1 from the cycle after an accepted start through the done cycle.
- R11: start while busy is ignored: the address, the method and the expected byte of the run in progress are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a completion check (accepted when idle) |
| use_toggle | input | 1 | 1 = toggle-bit method, 0 = data-complement polling |
| vaddr | input | ADDR_W | Program address or erasing-sector address |
| expect_stat | input | 8 | Expected data byte (0xFF for erase) |
| bus_req | output | 1 | Access request to the bus master |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data (return-to-read code) |
| bus_gnt | input | 1 | Request accepted by the bus master |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | DATA_W | Read data; status flags in the low byte |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded (with done) |
| fail | output | 1 | Operation failed or timed out (with done) |

## Verification
Both methods are swept over every mix of zero to two unfinished rounds, followed by each ending: immediate completion with the time-limit flag also set, the flag followed by completion, the flag followed by no completion, and never finishing. This separates a correct pass from a false pass on the flag, a missing recheck from an extra one, and the bound-driven fail from the flag-driven fail. Read latency changes from case to case, and the bench drives inverted data while read-valid is low, so a sample taken in the wrong cycle flips the verdict. One run pulses start in the middle of a check with a different address and method, which shows whether the latched values are kept.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RDREQ,
      ST_RDWAIT,
      ST_WRREQ,
      ST_FIN
   } cpe_state_e;

   typedef enum logic [1:0] {
      JG_CONT,
      JG_RECHECK,
      JG_PASS,
      JG_FAIL
   } cpe_judge_e;

   localparam int unsigned POS_DATA = 7;
   localparam int unsigned POS_TGL  = 6;
   localparam int unsigned POS_TMO  = 5;
   localparam logic [7:0]  RET_READ_CODE = 8'hF0;

endpackage

// File: rtl/cpe_status_judge.sv
module cpe_status_judge
   import cpe_pkg::*;
(
   input  logic       toggle_mode,
   input  logic       recheck,
   input  logic [7:0] cur_stat,
   input  logic [7:0] prev_stat,
   input  logic [7:0] expect_stat,
   output cpe_judge_e verdict
);

   logic finished;

   always_comb begin
      if (toggle_mode)
         finished = (cur_stat[POS_TGL] == prev_stat[POS_TGL]);
      else
         finished = (cur_stat[POS_DATA] == expect_stat[POS_DATA]);
   end

   always_comb begin
      if (finished)
         verdict = JG_PASS;
      else if (recheck)
         verdict = JG_FAIL;
      else if (cur_stat[POS_TMO])
         verdict = JG_RECHECK;
      else
         verdict = JG_CONT;
   end

endmodule

// File: rtl/cpe_poll_limit.sv
module cpe_poll_limit #(
   parameter int unsigned MAX_POLLS = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);

   localparam int unsigned CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_POLLS - 1);

   generate
      if (MAX_POLLS < 1) begin : g_bad_limit
         $error("cpe_poll_limit: MAX_POLLS must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         cnt <= '0;
      else if (step && cnt != CNT_LAST)
         cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CNT_LAST);

   // R9
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_LAST);

endmodule

// File: rtl/cpe_engine.sv
module cpe_engine
   import cpe_pkg::*;
#(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned MAX_POLLS = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              use_toggle,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [7:0]        expect_stat,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              bus_rvalid,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              fail
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("cpe_engine: DATA_W must be at least 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("cpe_engine: ADDR_W must be at least 1");
      end
      if (DATA_W > 8) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^bus_rdata[DATA_W-1:8];
      end
   endgenerate

   cpe_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        exp_q;
   logic [7:0]        first_q;
   logic              mode_q;
   logic              recheck_q;
   logic              second_q;
   logic              verdict_q;

   logic              accept_start;
   logic              judge_now;
   logic              lim_last;
   logic              lim_step;
   cpe_judge_e        verdict;

   assign accept_start = (state == ST_IDLE) && start;
   assign judge_now    = (state == ST_RDWAIT) && bus_rvalid && (!mode_q || second_q);
   assign lim_step     = judge_now && (verdict == JG_CONT);

   cpe_status_judge u_judge (
      .toggle_mode (mode_q),
      .recheck     (recheck_q),
      .cur_stat    (bus_rdata[7:0]),
      .prev_stat   (first_q),
      .expect_stat (exp_q),
      .verdict     (verdict)
   );

   cpe_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept_start),
      .step  (lim_step),
      .last  (lim_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr_q    <= '0;
         exp_q     <= '0;
         first_q   <= '0;
         mode_q    <= 1'b0;
         recheck_q <= 1'b0;
         second_q  <= 1'b0;
         verdict_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  addr_q    <= vaddr;
                  exp_q     <= expect_stat;
                  mode_q    <= use_toggle;
                  recheck_q <= 1'b0;
                  second_q  <= 1'b0;
                  verdict_q <= 1'b0;
                  state     <= ST_RDREQ;
               end
            end
            ST_RDREQ: begin
               if (bus_gnt) state <= ST_RDWAIT;
            end
            ST_RDWAIT: begin
               if (bus_rvalid) begin
                  if (mode_q && !second_q) begin
                     first_q  <= bus_rdata[7:0];
                     second_q <= 1'b1;
                     state    <= ST_RDREQ;
                  end else begin
                     second_q <= 1'b0;
                     unique case (verdict)
                        JG_PASS: begin
                           verdict_q <= 1'b1;
                           state     <= ST_FIN;
                        end
                        JG_FAIL:    state <= ST_WRREQ;
                        JG_RECHECK: begin
                           recheck_q <= 1'b1;
                           state     <= ST_RDREQ;
                        end
                        default:    state <= lim_last ? ST_WRREQ : ST_RDREQ;
                     endcase
                  end
               end
            end
            ST_WRREQ: begin
               if (bus_gnt) state <= ST_FIN;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign bus_req   = (state == ST_RDREQ) || (state == ST_WRREQ);
   assign bus_we    = (state == ST_WRREQ);
   assign bus_addr  = addr_q;
   assign bus_wdata = DATA_W'(RET_READ_CODE);
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign pass      = done && verdict_q;
   assign fail      = done && !verdict_q;

   // R7
   req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_gnt |=> !bus_req);

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R6
   fail_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> $past(bus_req && bus_we && bus_gnt));

   // R11
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(bus_addr));

endmodule

// File: tb/cpe_engine_tb.sv
module cpe_engine_tb;

   localparam int unsigned AW   = 18;
   localparam int unsigned DW   = 16;
   localparam int unsigned MAXP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          use_toggle = 1'b0;
   logic [AW-1:0] vaddr = '0;
   logic [7:0]    expect_stat = '0;
   logic          bus_req, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_gnt;
   logic          bus_rvalid;
   logic [DW-1:0] bus_rdata;
   logic          busy, done, pass, fail;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   logic [DW-1:0] script [0:31];
   logic [AW-1:0] cur_addr = '0;
   int            cfg_lat = 1;
   logic          clr = 1'b0;

   int            lat_cnt, rd_idx, rd_cnt, wr_cnt, bad_addr;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   always #4 clk = ~clk;

   cpe_engine #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .use_toggle(use_toggle),
      .vaddr(vaddr), .expect_stat(expect_stat),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .pass(pass), .fail(fail)
   );

   // bus master model: grant one cycle after request, read data after cfg_lat cycles
   always @(posedge clk) begin
      if (!rst_n || clr) begin
         bus_gnt <= 1'b0; bus_rvalid <= 1'b0; bus_rdata <= '0;
         lat_cnt <= 0; rd_idx <= 0; rd_cnt <= 0; wr_cnt <= 0; bad_addr <= 0;
         wr_addr <= '0; wr_data <= '0;
      end else begin
         bus_gnt <= bus_req && !bus_gnt;
         if (bus_req && bus_gnt) begin
            if (bus_addr != cur_addr) bad_addr <= bad_addr + 1;
            if (bus_we) begin
               wr_cnt <= wr_cnt + 1; wr_addr <= bus_addr; wr_data <= bus_wdata;
            end else begin
               rd_cnt <= rd_cnt + 1; lat_cnt <= cfg_lat;
            end
         end
         if (lat_cnt == 1) begin
            bus_rvalid <= 1'b1;
            bus_rdata  <= script[rd_idx];
            rd_idx     <= rd_idx + 1;
         end else begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= ~script[rd_idx];
         end
         if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
      end
   end

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mk(input bit b7, input bit b6, input bit b5, input int i);
      mk = 16'hC300 | DW'(i & 31);
      mk[7] = b7; mk[6] = b6; mk[5] = b5;
      mk[4:0] = 5'(i);
   endfunction

   // expected outcome derived from the requirements
   task automatic ref_eval(input bit tg, input logic [7:0] e, output bit ok, output int nrd);
      int polls = 0;
      bit rc = 0;
      bit fin = 0;
      logic [DW-1:0] a, b;
      nrd = 0; ok = 0;
      while (!fin) begin
         if (!tg) begin
            a = script[nrd]; nrd++;
            if (a[7] == e[7]) begin ok = 1; fin = 1; end
            else if (rc) fin = 1;
            else if (a[5]) rc = 1;
            else begin polls++; if (polls == MAXP) fin = 1; end
         end else begin
            a = script[nrd]; b = script[nrd+1]; nrd += 2;
            if (a[6] == b[6]) begin ok = 1; fin = 1; end
            else if (rc) fin = 1;
            else if (b[5]) rc = 1;
            else begin polls++; if (polls == MAXP) fin = 1; end
         end
      end
   endtask

   task automatic run_case(input bit tg, input logic [AW-1:0] a, input logic [7:0] e,
                           input int lat, input bit poke, input string tag);
      bit ok; int nrd; int n = 0; bit got_pass, got_fail;
      ref_eval(tg, e, ok, nrd);
      @(negedge clk); clr = 1'b1; cur_addr = a; cfg_lat = lat;
      @(negedge clk); clr = 1'b0;
      start = 1'b1; use_toggle = tg; vaddr = a; expect_stat = e;
      @(negedge clk); start = 1'b0;
      while (!done && n < 3000) begin
         if (poke && n == 3) begin
            start = 1'b1; use_toggle = ~tg; vaddr = ~a; expect_stat = ~e;
         end else start = 1'b0;
         @(negedge clk); n++;
      end
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy at done", busy, 1);
      got_pass = pass; got_fail = fail;
      // R8: verdict wrong if data is sampled outside rvalid
      chk(got_pass == ok && got_fail == !ok, tag, {got_pass, got_fail}, {ok, !ok});
      chk(rd_cnt == nrd, {tag, " read count"}, rd_cnt, nrd);
      chk(wr_cnt == (ok ? 0 : 1), "R6 write count", wr_cnt, ok ? 0 : 1);
      if (!ok) chk(wr_data == 16'h00F0 && wr_addr == a, "R6 write data", wr_data, 16'h00F0);
      chk(bad_addr == 0, poke ? "R11 address kept" : "R2 read address", bad_addr, 0);
      @(negedge clk);
      chk(!done && !busy, "R10 done pulse", {done, busy}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(!bus_req && !busy && !done && !pass && !fail, "R1 reset state",
          {bus_req, busy, done, pass, fail}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_req && !busy && !done, "R1 idle after reset", {bus_req, busy, done}, 0);

      for (int tg = 0; tg < 2; tg++)
         for (int eb = 0; eb < 2; eb++)
            for (int nb = 0; nb < 3; nb++)
               for (int tl = 0; tl < 4; tl++) begin
                  logic [7:0] e = eb ? 8'hFF : 8'h3C;
                  bit e7 = e[7];
                  int t = tg ? 2 * nb : nb;
                  string tag;
                  for (int i = 0; i < 32; i++) script[i] = mk(~e7, i[0], 1'b0, i);
                  if (!tg) begin
                     if (tl == 0) script[t] = mk(e7, 1'b0, 1'b1, t);
                     if (tl == 1) begin script[t] = mk(~e7, 1'b0, 1'b1, t); script[t+1] = mk(e7, 1'b1, 1'b0, t+1); end
                     if (tl == 2) begin script[t] = mk(~e7, 1'b0, 1'b1, t); script[t+1] = mk(~e7, 1'b1, 1'b0, t+1); end
                     tag = (tl == 3) ? "R9 poll limit" : (tl == 0 ? "R2 poll result" : "R3 poll recheck");
                  end else begin
                     if (tl == 0) begin script[t] = mk(~e7, 1'b1, 1'b0, t); script[t+1] = mk(~e7, 1'b1, 1'b1, t+1); end
                     if (tl == 1) begin
                        script[t] = mk(~e7, 1'b0, 1'b0, t); script[t+1] = mk(~e7, 1'b1, 1'b1, t+1);
                        script[t+2] = mk(~e7, 1'b0, 1'b0, t+2); script[t+3] = mk(~e7, 1'b0, 1'b0, t+3);
                     end
                     if (tl == 2) begin
                        script[t] = mk(~e7, 1'b0, 1'b0, t); script[t+1] = mk(~e7, 1'b1, 1'b1, t+1);
                        script[t+2] = mk(~e7, 1'b1, 1'b0, t+2); script[t+3] = mk(~e7, 1'b0, 1'b0, t+3);
                     end
                     tag = (tl == 3) ? "R9 toggle limit" : (tl == 0 ? "R4 toggle result" : "R5 toggle recheck");
                  end
                  run_case(tg[0], AW'(18'h01357 * (nb + 1) + tl * 18'h00F1 + eb), e,
                           1 + ((nb + tl) % 3), 1'b0, tag);
               end

      // R11: start pulsed mid-run with other address, method and expected byte
      for (int i = 0; i < 32; i++) script[i] = mk(1'b0, i[0], 1'b0, i);
      script[4] = mk(1'b1, 1'b0, 1'b0, 4);
      run_case(1'b0, 18'h2A5A5, 8'hFF, 2, 1'b1, "R11 result kept");

      summary();
      $finish;
   end

endmodule